// File: doc/BRIEF.md
# Register-Write Command List Executor

This block walks a list of register-write instructions held in memory and replays them onto a local register bus. Software first turns the engine on and writes a start pointer. It then writes an end pointer, and that write starts the run. The engine fetches 32-bit words one at a time through a request/response memory port, decodes each 8-byte-aligned instruction, and issues writes with byte enables on a register-write master port. When it reaches the end pointer it drops its busy flag. The engine never reads registers.

There are two instruction formats. In both, bits [31:24] of the second word carry the opcode. A single write (0x1) puts its data in the first word; its second word holds the byte enable in bits [23:20] and the 20-bit register offset in bits [19:0]. A burst write (0x9) puts a word count N in the first word and the base offset in bits [19:0] of the second word. N data words follow, going to the base, base+4, base+8 and so on, with all four byte lanes enabled. When 2+N is odd, one pad word follows so that the next instruction starts on an 8-byte boundary. Any other opcode, including an all-zero pair, is skipped.

Both data ports use valid/ready. A memory request holds its address until `mem_req_ready` is high, and only one word is ever outstanding; the engine raises `mem_rsp_ready` only while it waits for that word. A register write holds its address, data and byte enable until `reg_wr_ready` is high. Either side may stall for any number of cycles.

Top module: `cmdlist_exec`

## Requirements
- R1: After reset, `enabled`, `busy` and `err` are 0, and neither `mem_req_valid` nor `reg_wr_valid` is asserted.
- R2: A config write with `cfg_sel`=2 (end pointer), made while `enabled`=1 and `busy`=0, raises `busy` in the next cycle. `busy` stays high until every instruction below the end pointer has been consumed, then falls. `cfg_sel`=0 writes the enable (bit 0) and `cfg_sel`=1 writes the start pointer.
- R3: Opcode 0x01 in bits [31:24] of the second word gives exactly one register write. Its data is the first word, its byte enable is bits [23:20] and its address is bits [19:0].
- R4: Opcode 0x09 with count N in the first word gives N register writes, in order. Write k carries data word k and goes to address base+4k, taken modulo 2^20, with byte enable 4'hF.
- R5: After a burst with an odd total word count, the pad word is skipped, and the next instruction is decoded from the next 8-byte boundary.
- R6: Any other opcode, including all-zero words, gives no write and moves on by 8 bytes. A burst with N=0 also gives no write and moves on by 8 bytes.
- R7: Execution stops at the first instruction boundary at or beyond the end pointer. Zero fill below the end pointer gives no writes. While `busy`=0, no memory request and no register write is issued.
- R8: An end-pointer write made while busy or while not enabled is ignored: nothing starts and the stored end pointer is unchanged. Start-pointer and enable writes made while busy are also ignored. Each ignored write sets the sticky `err` flag, which only reset clears.
- R9: `mem_req_valid` stays high, with `mem_req_addr` stable and word-aligned, until `mem_req_ready` is high. A new request is issued only after the previous response has been accepted.
- R10: `reg_wr_valid` stays high, with address, data and byte enable stable, until `reg_wr_ready` is high. The sequence of writes is the same under any back-pressure on either port.
- R11: If the start and end pointers are equal, `busy` is high for exactly one cycle and no memory request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_sel | input | 2 | Config target: 0 enable, 1 start pointer, 2 end pointer |
| cfg_wdata | input | MEM_AW | Config write data |
| enabled | output | 1 | Engine enable state |
| busy | output | 1 | Executing the list |
| err | output | 1 | Sticky flag for ignored config writes |
| mem_req_valid | output | 1 | Memory word request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | MEM_AW | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_ready | output | 1 | Engine is waiting for a response |
| mem_rsp_data | input | 32 | Returned word |
| reg_wr_valid | output | 1 | Register write valid |
| reg_wr_ready | input | 1 | Register bus accepts the write |
| reg_wr_addr | output | 20 | Register offset |
| reg_wr_data | output | 32 | Write data |
| reg_wr_be | output | 4 | Byte enables |

## Verification
One list mixes every instruction kind: single writes with full and partial byte enables, odd and even bursts (one of which wraps the 20-bit offset), a zero-count burst, an all-zero pair, an unknown opcode, and zero fill up to a 64-byte-aligned end pointer. Replaying this list with both ports free-running checks decoding and pad skipping. Replaying it under heavy stalls on both ports separates real handshake behaviour from timing luck. Directed runs cover an end-pointer write while disabled and one while busy; the busy case would cut the run short if it were accepted. A final run with equal pointers checks the one-cycle busy pulse.

// File: rtl/cle_pkg.sv
package cle_pkg;
  localparam int WORD_W   = 32;
  localparam int REG_AW   = 20;
  localparam int BE_W     = 4;
  localparam int OPC_LSB  = 24;
  localparam int BE_LSB   = 20;
  localparam logic [7:0] OPC_SINGLE  = 8'h01;
  localparam logic [7:0] OPC_INDEXED = 8'h09;
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_HEAD = 2'd1;
  localparam logic [1:0] SEL_TAIL = 2'd2;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_BOUND, SQ_RD0, SQ_ISS1, SQ_RD1,
    SQ_DECODE, SQ_WR, SQ_ISSD, SQ_RDD, SQ_WRD
  } seq_state_e;

  typedef enum logic [1:0] {RD_IDLE, RD_REQ, RD_WAIT} rd_state_e;
endpackage

// File: rtl/cle_csr.sv
module cle_csr #(
  parameter int MEM_AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [MEM_AW-1:0] cfg_wdata,
  input  logic              busy,
  output logic              enable,
  output logic [MEM_AW-1:0] head,
  output logic [MEM_AW-1:0] tail,
  output logic              start,
  output logic              err
);
  import cle_pkg::*;

  logic sel_valid, reject;

  always_comb begin
    sel_valid = (cfg_sel != 2'd3);
    start     = cfg_we && (cfg_sel == SEL_TAIL) && enable && !busy;
    reject    = cfg_we && ((busy && sel_valid) || ((cfg_sel == SEL_TAIL) && !enable));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable <= 1'b0;
      head   <= '0;
      tail   <= '0;
      err    <= 1'b0;
    end else begin
      if (cfg_we && !busy) begin
        if (cfg_sel == SEL_CTRL) enable <= cfg_wdata[0];
        if (cfg_sel == SEL_HEAD) head   <= cfg_wdata;
      end
      if (start) tail <= cfg_wdata;
      if (reject) err <= 1'b1;
    end
  end

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R8
  tail_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(tail));
endmodule

// File: rtl/cle_word_reader.sv
module cle_word_reader #(
  parameter int MEM_AW = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       go,
  input  logic [MEM_AW-1:0]          go_addr,
  output logic                       done,
  output logic [cle_pkg::WORD_W-1:0] rdata,
  output logic                       mem_req_valid,
  input  logic                       mem_req_ready,
  output logic [MEM_AW-1:0]          mem_req_addr,
  input  logic                       mem_rsp_valid,
  output logic                       mem_rsp_ready,
  input  logic [cle_pkg::WORD_W-1:0] mem_rsp_data
);
  import cle_pkg::*;

  rd_state_e state;
  logic [MEM_AW-1:0] addr_q;

  assign mem_req_valid = (state == RD_REQ);
  assign mem_rsp_ready = (state == RD_WAIT);
  assign mem_req_addr  = addr_q;
  assign done          = mem_rsp_valid && mem_rsp_ready;
  assign rdata         = mem_rsp_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= RD_IDLE;
      addr_q <= '0;
    end else begin
      case (state)
        RD_IDLE: if (go) begin
          addr_q <= go_addr;
          state  <= RD_REQ;
        end
        RD_REQ:  if (mem_req_ready) state <= RD_WAIT;
        RD_WAIT: if (mem_rsp_valid) state <= RD_IDLE;
        default: state <= RD_IDLE;
      endcase
    end
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R9
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

  // R9
  go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (state == RD_IDLE));
endmodule

// File: rtl/cle_wr_master.sv
module cle_wr_master (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       go,
  input  logic [cle_pkg::REG_AW-1:0] go_addr,
  input  logic [cle_pkg::WORD_W-1:0] go_data,
  input  logic [cle_pkg::BE_W-1:0]   go_be,
  output logic                       done,
  output logic                       reg_wr_valid,
  input  logic                       reg_wr_ready,
  output logic [cle_pkg::REG_AW-1:0] reg_wr_addr,
  output logic [cle_pkg::WORD_W-1:0] reg_wr_data,
  output logic [cle_pkg::BE_W-1:0]   reg_wr_be
);
  assign done = reg_wr_valid && reg_wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_wr_valid <= 1'b0;
      reg_wr_addr  <= '0;
      reg_wr_data  <= '0;
      reg_wr_be    <= '0;
    end else if (go) begin
      reg_wr_valid <= 1'b1;
      reg_wr_addr  <= go_addr;
      reg_wr_data  <= go_data;
      reg_wr_be    <= go_be;
    end else if (done) begin
      reg_wr_valid <= 1'b0;
    end
  end

  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_valid && !reg_wr_ready |=> reg_wr_valid && $stable(reg_wr_addr)
      && $stable(reg_wr_data) && $stable(reg_wr_be));

  // R10
  no_clobber_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !reg_wr_valid);
endmodule

// File: rtl/cle_sequencer.sv
module cle_sequencer #(
  parameter int MEM_AW = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [MEM_AW-1:0]          head,
  input  logic [MEM_AW-1:0]          tail,
  output logic                       busy,
  output logic                       rd_go,
  output logic [MEM_AW-1:0]          rd_addr,
  input  logic                       rd_done,
  input  logic [cle_pkg::WORD_W-1:0] rd_data,
  output logic                       wr_go,
  output logic [cle_pkg::REG_AW-1:0] wr_addr,
  output logic [cle_pkg::WORD_W-1:0] wr_data,
  output logic [cle_pkg::BE_W-1:0]   wr_be,
  input  logic                       wr_done
);
  import cle_pkg::*;

  localparam logic [MEM_AW-1:0] STEP4  = MEM_AW'(4);
  localparam logic [MEM_AW-1:0] STEP8  = MEM_AW'(8);
  localparam logic [MEM_AW-1:0] ALIGN8 = ~MEM_AW'(7);
  localparam logic [REG_AW-1:0] RSTEP  = REG_AW'(4);

  seq_state_e        state;
  logic [MEM_AW-1:0] ptr, dptr, tail_al, burst_end, next_ptr;
  logic [WORD_W-1:0] w0, w1, remain;
  logic [REG_AW-1:0] idx_addr;
  logic [7:0]        opcode;
  logic              at_end;

  always_comb begin
    tail_al   = tail & ALIGN8;
    at_end    = (ptr >= tail_al);
    opcode    = w1[WORD_W-1:OPC_LSB];
    burst_end = dptr + STEP4;
    next_ptr  = burst_end[2] ? (burst_end + STEP4) : burst_end;
    busy      = (state != SQ_IDLE);
    rd_go     = ((state == SQ_BOUND) && !at_end) || (state == SQ_ISS1) || (state == SQ_ISSD);
    rd_addr   = (state == SQ_ISS1) ? (ptr + STEP4) : ((state == SQ_ISSD) ? dptr : ptr);
    wr_go     = ((state == SQ_DECODE) && (opcode == OPC_SINGLE)) || ((state == SQ_RDD) && rd_done);
    wr_addr   = (state == SQ_DECODE) ? w1[REG_AW-1:0] : idx_addr;
    wr_data   = (state == SQ_DECODE) ? w0 : rd_data;
    wr_be     = (state == SQ_DECODE) ? w1[BE_LSB+BE_W-1:BE_LSB] : {BE_W{1'b1}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      ptr      <= '0;
      dptr     <= '0;
      w0       <= '0;
      w1       <= '0;
      remain   <= '0;
      idx_addr <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (start) begin
          ptr   <= head & ALIGN8;
          state <= SQ_BOUND;
        end
        SQ_BOUND: state <= at_end ? SQ_IDLE : SQ_RD0;
        SQ_RD0: if (rd_done) begin
          w0    <= rd_data;
          state <= SQ_ISS1;
        end
        SQ_ISS1: state <= SQ_RD1;
        SQ_RD1: if (rd_done) begin
          w1    <= rd_data;
          state <= SQ_DECODE;
        end
        SQ_DECODE: begin
          if (opcode == OPC_SINGLE) begin
            state <= SQ_WR;
          end else if (opcode == OPC_INDEXED) begin
            remain   <= w0;
            idx_addr <= w1[REG_AW-1:0];
            dptr     <= ptr + STEP8;
            if (w0 == '0) begin
              ptr   <= ptr + STEP8;
              state <= SQ_BOUND;
            end else begin
              state <= SQ_ISSD;
            end
          end else begin
            ptr   <= ptr + STEP8;
            state <= SQ_BOUND;
          end
        end
        SQ_WR: if (wr_done) begin
          ptr   <= ptr + STEP8;
          state <= SQ_BOUND;
        end
        SQ_ISSD: state <= SQ_RDD;
        SQ_RDD:  if (rd_done) state <= SQ_WRD;
        SQ_WRD: if (wr_done) begin
          idx_addr <= idx_addr + RSTEP;
          dptr     <= dptr + STEP4;
          remain   <= remain - 1'b1;
          if (remain == WORD_W'(1)) begin
            ptr   <= next_ptr;
            state <= SQ_BOUND;
          end else begin
            state <= SQ_ISSD;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R5
  boundary_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_BOUND) |-> (ptr[2:0] == 3'b000));

  // R2
  finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_BOUND) && at_end |=> !busy);
endmodule

// File: rtl/cmdlist_exec.sv
module cmdlist_exec #(
  parameter int MEM_AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [MEM_AW-1:0] cfg_wdata,
  output logic              enabled,
  output logic              busy,
  output logic              err,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [MEM_AW-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [31:0]       mem_rsp_data,
  output logic              reg_wr_valid,
  input  logic              reg_wr_ready,
  output logic [19:0]       reg_wr_addr,
  output logic [31:0]       reg_wr_data,
  output logic [3:0]        reg_wr_be
);
  import cle_pkg::*;

  logic [MEM_AW-1:0] head, tail, rd_addr;
  logic              start, rd_go, rd_done, wr_go, wr_done;
  logic [WORD_W-1:0] rd_data, wr_data;
  logic [REG_AW-1:0] wr_addr;
  logic [BE_W-1:0]   wr_be;

  cle_csr #(.MEM_AW(MEM_AW)) u_csr (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .busy(busy), .enable(enabled), .head(head),
    .tail(tail), .start(start), .err(err)
  );

  cle_sequencer #(.MEM_AW(MEM_AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .head(head), .tail(tail),
    .busy(busy), .rd_go(rd_go), .rd_addr(rd_addr), .rd_done(rd_done),
    .rd_data(rd_data), .wr_go(wr_go), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_be(wr_be), .wr_done(wr_done)
  );

  cle_word_reader #(.MEM_AW(MEM_AW)) u_rd (
    .clk(clk), .rst_n(rst_n), .go(rd_go), .go_addr(rd_addr),
    .done(rd_done), .rdata(rd_data), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_data(mem_rsp_data)
  );

  cle_wr_master u_wr (
    .clk(clk), .rst_n(rst_n), .go(wr_go), .go_addr(wr_addr),
    .go_data(wr_data), .go_be(wr_be), .done(wr_done),
    .reg_wr_valid(reg_wr_valid), .reg_wr_ready(reg_wr_ready),
    .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_wr_be(reg_wr_be)
  );

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && (cfg_sel == SEL_TAIL) && enabled && !busy |=> busy);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid && !reg_wr_valid);
endmodule

// File: tb/sim_cmdlist_exec.sv
module sim_cmdlist_exec;
  localparam int CLK_PERIOD = 10;
  localparam int NPROG = 8;
  localparam logic [31:0] HEAD_B = 32'h40;
  localparam logic [31:0] TAIL_B = 32'hC0;
  // entry: {kind[1:0], offset[19:0], value[31:0], be[3:0]}
  // kind 0 single, 1 burst (value = count), 2 zero pair, 3 unknown opcode
  localparam logic [57:0] PROG [NPROG] = '{
    {2'd0, 20'h00010, 32'h1111_2222, 4'hF},
    {2'd1, 20'h00200, 32'd3,         4'h0},
    {2'd0, 20'h00034, 32'hDEAD_BEEF, 4'h5},
    {2'd2, 20'h00000, 32'h0,         4'h0},
    {2'd1, 20'hFFFF8, 32'd4,         4'h0},
    {2'd1, 20'h00300, 32'd0,         4'h0},
    {2'd0, 20'h00044, 32'h0000_00AB, 4'h1},
    {2'd3, 20'h12345, 32'hFFFF_FFFF, 4'h0}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        enabled, busy, err;
  logic        mem_req_valid, mem_rsp_ready, reg_wr_valid;
  logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0, reg_wr_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_rsp_data = '0, reg_wr_data;
  logic [19:0] reg_wr_addr;
  logic [3:0]  reg_wr_be;

  logic [31:0] mem [256];
  logic [19:0] exp_a [32];
  logic [31:0] exp_d [32];
  logic [3:0]  exp_b [32];
  string       exp_t [32];
  int exp_n = 0, got_n = 0, req_cnt = 0, errs = 0, total = 0, cyc = 0;
  bit stall = 1'b0, finished = 1'b0;

  cmdlist_exec u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // memory responder and register sink, all decisions at the falling edge
  initial begin
    bit req_taken, rsp_taken, pend;
    int pdelay;
    logic [7:0] paddr;
    req_taken = 0; rsp_taken = 0; pend = 0; pdelay = 0; paddr = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rsp_taken) begin mem_rsp_valid = 1'b0; rsp_taken = 0; end
      if (req_taken) begin pend = 1; pdelay = stall ? 2 : 0; req_taken = 0; end
      if (pend && !mem_rsp_valid) begin
        if (pdelay == 0) begin
          mem_rsp_valid = 1'b1; mem_rsp_data = mem[paddr]; pend = 0;
        end else pdelay--;
      end
      mem_req_ready = stall ? (cyc % 4 == 0) : 1'b1;
      if (mem_req_valid && mem_req_ready) begin
        req_taken = 1; paddr = mem_req_addr[9:2]; req_cnt++;
      end
      if (mem_rsp_valid && mem_rsp_ready) rsp_taken = 1;
      reg_wr_ready = stall ? (cyc % 3 == 0) : 1'b1;
      if (reg_wr_valid && reg_wr_ready) begin
        if (got_n < exp_n) begin
          chk(reg_wr_addr == exp_a[got_n], exp_t[got_n], 32'(reg_wr_addr), 32'(exp_a[got_n]));
          chk(reg_wr_data == exp_d[got_n], exp_t[got_n], reg_wr_data, exp_d[got_n]);
          chk(reg_wr_be == exp_b[got_n], exp_t[got_n], 32'(reg_wr_be), 32'(exp_b[got_n]));
        end else chk(1'b0, "R7 extra write", 32'(reg_wr_addr), 32'hFFFF_FFFF);
        got_n++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, total);
      $finish;
    end
  end

  task automatic cfg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
  endtask

  task automatic build();
    int w;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    w = int'(HEAD_B) / 4;
    for (int i = 0; i < NPROG; i++) begin
      logic [1:0]  kind;
      logic [19:0] off;
      logic [31:0] val;
      logic [3:0]  be;
      {kind, off, val, be} = PROG[i];
      case (kind)
        2'd0: begin // R3 single write
          mem[w] = val; mem[w+1] = {8'h01, be, off};
          exp_a[exp_n] = off; exp_d[exp_n] = val; exp_b[exp_n] = be; exp_t[exp_n] = "R3";
          exp_n++; w += 2;
        end
        2'd1: begin // R4 burst, R5 pad when odd
          mem[w] = val; mem[w+1] = {8'h09, 4'h0, off};
          for (int k = 0; k < int'(val); k++) begin
            mem[w+2+k] = 32'hA500_0000 + 32'(i * 256 + k);
            exp_a[exp_n] = off + 20'(4 * k); exp_d[exp_n] = mem[w+2+k];
            exp_b[exp_n] = 4'hF; exp_t[exp_n] = "R4";
            exp_n++;
          end
          w += 2 + int'(val);
          if (w % 2 == 1) w++;
        end
        2'd2: w += 2; // R6 zero pair
        default: begin // R6 unknown opcode
          mem[w] = val; mem[w+1] = {8'h05, 4'h0, off};
          w += 2;
        end
      endcase
    end
  endtask

  task automatic run_list(input bit stl, input string tag);
    stall = stl; got_n = 0;
    cfg(2'd2, TAIL_B);
    chk(busy == 1'b1, "R2 busy after start", 32'(busy), 1);
    wait_idle();
    chk(busy == 1'b0, "R2 busy falls", 32'(busy), 0);
    chk(got_n == exp_n, tag, 32'(got_n), 32'(exp_n));
  endtask

  initial begin
    int rq;
    build();
    do_reset();
    // R1 reset state
    chk(enabled == 1'b0, "R1 enabled", 32'(enabled), 0);
    chk(busy == 1'b0, "R1 busy", 32'(busy), 0);
    chk(err == 1'b0, "R1 err", 32'(err), 0);
    chk(!mem_req_valid && !reg_wr_valid, "R1 ports quiet", 32'({mem_req_valid, reg_wr_valid}), 0);

    // R8 end pointer while disabled is ignored
    cfg(2'd1, HEAD_B);
    cfg(2'd2, TAIL_B);
    chk(busy == 1'b0, "R8 disabled tail no start", 32'(busy), 0);
    chk(err == 1'b1, "R8 disabled tail err", 32'(err), 1);
    repeat (20) @(negedge clk);
    chk(req_cnt == 0 && got_n == 0, "R8 disabled tail no traffic", 32'(req_cnt + got_n), 0);
    do_reset();
    chk(err == 1'b0, "R8 err cleared by reset", 32'(err), 0);

    cfg(2'd0, 32'h1);
    chk(enabled == 1'b1, "R2 enable", 32'(enabled), 1);
    cfg(2'd1, HEAD_B);
    run_list(1'b0, "R5 R6 R7 write count free-running");
    chk(err == 1'b0, "R8 no err on legal run", 32'(err), 0);
    run_list(1'b1, "R10 write count stalled");

    // R8 end pointer rewrite while busy is ignored
    stall = 1'b1; got_n = 0;
    cfg(2'd2, TAIL_B);
    repeat (4) @(negedge clk);
    cfg(2'd2, HEAD_B);
    chk(err == 1'b1, "R8 busy tail err", 32'(err), 1);
    wait_idle();
    chk(got_n == exp_n, "R8 busy tail ignored", 32'(got_n), 32'(exp_n));

    // R11 equal pointers
    stall = 1'b0;
    cfg(2'd1, 32'h100);
    rq = req_cnt;
    cfg(2'd2, 32'h100);
    chk(busy == 1'b1, "R11 one-cycle busy high", 32'(busy), 1);
    @(negedge clk);
    chk(busy == 1'b0, "R11 busy low after one cycle", 32'(busy), 0);
    chk(req_cnt == rq, "R11 no fetch", 32'(req_cnt - rq), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule